// File: doc/BRIEF.md
# Programmable Power-of-Two Clock Prescaler with Guarded Update

This block sits in the clock path of a small subsystem. It divides a fast source clock by 1, 2, 4 and so on up to 256, and produces one common system clock-enable pulse. The processor, the peripherals and the memory domain all use that same pulse. A free-running counter clocked by the undivided source generates the pulse, so the source may run much faster than the resulting system rate.

Software can change the division ratio only through an eight-bit control register, and only after a short unlock sequence. First it writes the arming value 0x80. Then, within four bus cycles, it writes the wanted divisor code with the top bit clear. Any other form of access leaves the ratio alone. The accepted code is held as pending. It takes effect only when the counter wraps at the old terminal count. As a result the pulse train never contains a short period and never runs at any rate other than the old one or the new one.

Top module: `clk_prescaler`

## Requirements
- R1: After synchronous reset the readback is the parameter RESET_CODE with the arm bit clear, and ticks repeat every 2^RESET_CODE source cycles.
- R2: With divisor code c active, `sys_tick` is high for exactly one source cycle in every 2^c source cycles. For code 0 it is high on every cycle.
- R3: Only a bus-enabled write of exactly 0x80 arms the unlock window. A write with bit 7 set and any other bit set does not arm.
- R4: While armed, a bus-enabled write with bit 7 clear and a code in bits 3:0 from 0 to 8 replaces the divisor code and clears the arm bit. The readback shows the new code from the next cycle. Bits 6:4 of that write are ignored.
- R5: If four bus-enabled cycles pass after arming without a write, the arm bit clears. A divisor write after that has no effect.
- R6: While armed, a write carrying a reserved code (9 to 15), or one with bit 7 set other than 0x80, leaves the code unchanged and clears the arm bit.
- R7: While not armed, a write with bit 7 clear has no effect on the code.
- R8: Writes and window counting happen only on cycles with `bus_ce` high. Cycles with `bus_ce` low neither accept data nor shorten the window.
- R9: A new code takes effect at the next wrap of the old count. The next tick after the write comes within 2^old source cycles. Every later period equals 2^new. No period is shorter than either setting.
- R10: Readback format: bit 7 is the current arm state, bits 6:4 read zero, and bits 3:0 hold the selected code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| bus_ce | input | 1 | Bus cycle enable; qualifies writes and window counting |
| wr_data | input | 8 | Write data for the control register |
| rd_data | output | 8 | Control register readback |
| sys_tick | output | 1 | One-cycle system clock-enable pulse |

## Verification
A register access is due one source edge after the cycle that carries it. The bench drives each bus cycle at a falling edge and reads the register back at the next falling edge, so the model and the design are compared right after the single register stage.

Ticks come straight from the count register, so the bench counts falling edges to find timing. It counts from the write to the first visible tick, which must be fewer than 2^old edges. It counts from there to the next tick, which must be exactly 2^new. Because the bench always waits for that completed wrap before it starts the next change, every measured interval belongs to exactly one setting.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

    localparam int DATA_W   = 8;
    localparam int CODE_W   = 4;
    localparam int MAX_CODE = 8;
    localparam int CNT_W    = MAX_CODE;
    localparam int WIN_CYC  = 4;
    localparam int WIN_W    = $clog2(WIN_CYC + 1);
    localparam int ARM_BIT  = DATA_W - 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam data_t ARM_VALUE = data_t'(1) << ARM_BIT;

    typedef struct packed {
        logic        armed;
        logic [2:0]  zero;
        code_t       code;
    } ctrl_view_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_ARM,
        WR_LOAD,
        WR_DROP
    } wr_kind_t;

    function automatic logic code_ok(code_t c);
        return c <= code_t'(MAX_CODE);
    endfunction

    function automatic cnt_t term_of(code_t c);
        return CNT_W'(((CNT_W+1)'(1) << c) - (CNT_W+1)'(1));
    endfunction

    function automatic wr_kind_t classify(logic armed, data_t d);
        if (d == ARM_VALUE)
            return WR_ARM;
        else if (!armed)
            return WR_NONE;
        else if (!d[ARM_BIT] && code_ok(d[CODE_W-1:0]))
            return WR_LOAD;
        else
            return WR_DROP;
    endfunction

endpackage

// File: rtl/clkpre_unlock.sv
module clkpre_unlock
    import clkpre_pkg::*;
#(
    parameter int RESET_CODE = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  bus_ce,
    input  data_t wr_data,
    output logic  armed,
    output code_t sel_code
);

    logic              wr_go;
    wr_kind_t          kind;
    logic [WIN_W-1:0]  win_left;

    assign wr_go = wr_en & bus_ce;
    assign kind  = wr_go ? classify(armed, wr_data) : WR_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            win_left <= '0;
            sel_code <= code_t'(RESET_CODE);
        end else begin
            unique case (kind)
                WR_ARM: begin
                    armed    <= 1'b1;
                    win_left <= WIN_W'(WIN_CYC);
                end
                WR_LOAD: begin
                    sel_code <= wr_data[CODE_W-1:0];
                    armed    <= 1'b0;
                    win_left <= '0;
                end
                WR_DROP: begin
                    armed    <= 1'b0;
                    win_left <= '0;
                end
                default: begin
                    if (bus_ce && armed) begin
                        win_left <= win_left - WIN_W'(1);
                        if (win_left == WIN_W'(1))
                            armed <= 1'b0;
                    end
                end
            endcase
        end
    end

    AST_ARM_EXACT: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(wr_en && bus_ce && wr_data == ARM_VALUE)); // R3
    AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!armed && wr_en && bus_ce && !wr_data[ARM_BIT]) |=> $stable(sel_code)); // R7
    AST_IDLE_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_ce |=> ($stable(armed) && $stable(sel_code))); // R8
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        code_ok(sel_code)); // R6
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        armed |-> (win_left != '0 && win_left <= WIN_W'(WIN_CYC))); // R5

endmodule

// File: rtl/clkpre_divider.sv
module clkpre_divider
    import clkpre_pkg::*;
#(
    parameter int RESET_CODE = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t next_code,
    output logic  tick,
    output code_t active_code
);

    cnt_t cnt;
    cnt_t term;

    assign term = term_of(active_code);
    assign tick = (cnt == term);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            active_code <= code_t'(RESET_CODE);
        end else if (tick) begin
            cnt         <= '0;
            active_code <= next_code;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= term); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R2
    AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(active_code)); // R9

endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
    import clkpre_pkg::*;
#(
    parameter int RESET_CODE = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        bus_ce,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        sys_tick
);

    logic       armed;
    code_t      sel_code;
    code_t      active_code;
    ctrl_view_t view;

    clkpre_unlock #(.RESET_CODE(RESET_CODE)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .bus_ce   (bus_ce),
        .wr_data  (wr_data),
        .armed    (armed),
        .sel_code (sel_code)
    );

    clkpre_divider #(.RESET_CODE(RESET_CODE)) u_div (
        .clk         (clk),
        .rst         (rst),
        .next_code   (sel_code),
        .tick        (sys_tick),
        .active_code (active_code)
    );

    always_comb begin
        view.armed = armed;
        view.zero  = '0;
        view.code  = sel_code;
    end

    assign rd_data = view;

    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        code_ok(active_code)); // R9
    AST_RD_ZERO_FIELD: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:4] == 3'b000); // R10

endmodule

// File: tb/sim_clk_prescaler.sv
module sim_clk_prescaler;

    localparam int RST_CODE = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       bus_ce = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sys_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic       m_armed;
    int         m_win;
    logic [3:0] m_code;

    always #10 clk = ~clk;

    clk_prescaler #(.RESET_CODE(RST_CODE)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .bus_ce(bus_ce),
        .wr_data(wr_data), .rd_data(rd_data), .sys_tick(sys_tick)
    );

    function automatic logic [7:0] exp_rd();
        return {m_armed, 3'b000, m_code};
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_step(logic we, logic [7:0] d, logic ce);
        if (!ce) return;
        if (we) begin
            if (d == 8'h80) begin
                m_armed = 1'b1; m_win = 4;
            end else if (m_armed) begin
                if (!d[7] && d[3:0] <= 4'd8) m_code = d[3:0];
                m_armed = 1'b0; m_win = 0;
            end
        end else if (m_armed) begin
            m_win--;
            if (m_win == 0) m_armed = 1'b0;
        end
    endtask

    task automatic bus_cycle(logic we, logic [7:0] d, logic ce);
        wr_en = we; wr_data = d; bus_ce = ce;
        @(negedge clk);
        wr_en = 1'b0; bus_ce = 1'b0; wr_data = 8'h00;
        model_step(we, d, ce);
    endtask

    task automatic sync_tick(output int w);
        w = 0;
        while (!sys_tick) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sys_tick);
    endtask

    task automatic change_and_measure(logic [3:0] code);
        int old_div, w, g1, g2;
        old_div = 1 << m_code;
        bus_cycle(1'b1, 8'h80, 1'b1);
        check("R10 arm bit readback", int'(rd_data[7]), 1);
        bus_cycle(1'b1, {4'b0000, code}, 1'b1);
        check("R4 loaded code readback", int'(rd_data), int'(exp_rd()));
        sync_tick(w);
        check("R9 first tick within old period", int'(w < old_div), 1);
        gap(g1);
        gap(g2);
        check("R2 new period", g1, 1 << code);
        check("R9 steady new period", g2, 1 << code);
    endtask

    task automatic period_is(string req, int exp);
        int w, g;
        sync_tick(w);
        gap(g);
        check(req, g, exp);
    endtask

    initial begin
        int w, g;
        void'($urandom(32'h5EED_0042));
        m_armed = 1'b0; m_win = 0; m_code = 4'(RST_CODE);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset readback", int'(rd_data), RST_CODE);
        period_is("R1 reset period", 1 << RST_CODE);

        for (int c = 0; c <= 8; c++) change_and_measure(4'(c));
        change_and_measure(4'd2);

        // R5: window expiry after four idle bus cycles
        bus_cycle(1'b1, 8'h80, 1'b1);
        repeat (4) bus_cycle(1'b0, 8'h00, 1'b1);
        check("R5 arm cleared after window", int'(rd_data[7]), 0);
        bus_cycle(1'b1, 8'h05, 1'b1);
        check("R5 late write ignored", int'(rd_data), int'(exp_rd()));
        check("R5 code unchanged", int'(rd_data[3:0]), 2);
        period_is("R5 period unchanged", 4);

        // R4: write on the fourth bus cycle is still accepted
        bus_cycle(1'b1, 8'h80, 1'b1);
        repeat (3) bus_cycle(1'b0, 8'h00, 1'b1);
        bus_cycle(1'b1, 8'h71, 1'b1);
        check("R4 last-slot write, bits 6:4 ignored", int'(rd_data), 1);
        period_is("R4 last-slot period", 2);

        // R3: malformed arming values
        bus_cycle(1'b1, 8'h81, 1'b1);
        check("R3 0x81 does not arm", int'(rd_data[7]), 0);
        bus_cycle(1'b1, 8'hC0, 1'b1);
        check("R3 0xC0 does not arm", int'(rd_data[7]), 0);
        bus_cycle(1'b1, 8'h04, 1'b1);
        check("R7 unarmed write ignored", int'(rd_data), 1);

        // R6: reserved code consumes the window
        bus_cycle(1'b1, 8'h80, 1'b1);
        bus_cycle(1'b1, 8'h0B, 1'b1);
        check("R6 reserved code ignored", int'(rd_data), 1);
        bus_cycle(1'b1, 8'h03, 1'b1);
        check("R6 window consumed", int'(rd_data), 1);
        bus_cycle(1'b1, 8'h80, 1'b1);
        bus_cycle(1'b1, 8'h90, 1'b1);
        check("R6 bit7 write cancels", int'(rd_data), 1);

        // R8: cycles without bus_ce are invisible
        bus_cycle(1'b1, 8'h80, 1'b1);
        repeat (10) bus_cycle(1'b0, 8'h00, 1'b0);
        bus_cycle(1'b1, 8'h06, 1'b0);
        check("R8 write without bus_ce ignored", int'(rd_data), 8'h81);
        repeat (3) bus_cycle(1'b0, 8'h00, 1'b1);
        bus_cycle(1'b1, 8'h03, 1'b1);
        check("R8 window held across idle bus", int'(rd_data), 3);
        period_is("R8 period after load", 8);

        // Random mix against the bench model
        for (int it = 0; it < 40; it++) begin
            int steps = $urandom_range(1, 6);
            for (int s = 0; s < steps; s++) begin
                int sel = $urandom % 8;
                logic [7:0] d = 8'($urandom);
                case (sel)
                    0, 1: bus_cycle(1'b1, 8'h80, 1'b1);
                    2, 3: bus_cycle(1'b1, {1'b0, d[6:0]}, 1'b1);
                    4:    bus_cycle(1'b1, d, 1'b1);
                    5:    bus_cycle(1'b0, 8'h00, 1'b1);
                    6:    bus_cycle(1'b0, 8'h00, 1'b0);
                    default: bus_cycle(1'b1, d, 1'b0);
                endcase
                check("R4 R10 random readback", int'(rd_data), int'(exp_rd()));
            end
            sync_tick(w);
            gap(g);
            check("R2 random period", g, 1 << m_code);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule